// File: doc/BRIEF.md
# Framed Reply Message Encoder

This block turns a reply request from a register-bus master into a complete host frame. The frame is a byte stream sent to a UART transmitter over a valid/ready handshake. A request is one `start` pulse. It carries a message type, a start address and a payload length. Before issuing the request, the master fills a small first-word-fall-through FIFO with the payload bytes.

The encoder adds the opening and closing delimiters itself. It takes the payload from the FIFO one byte per accepted transfer and computes a CRC-8 as the bytes leave, then appends the checksum. The usual type codes are 0x07 for a reply and 0x18 for a status message. The encoder copies any type value through unchanged.

While a frame is in progress, `busy` is high and further requests are dropped. The serial bit timing and the decision of when to reply belong to neighbouring blocks.

Top module: `frm_encoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `tx_valid`, `busy` and `fifo_rd` are 0.
- R2: An accepted request produces exactly these bytes, in this order: 0x00, type, address, length, the payload bytes, CRC, 0x15. `tx_valid` is high with byte 0x00 in the cycle after the `start` cycle.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` keeps its value. The encoder moves to the next byte only after a cycle in which both are high.
- R4: The CRC byte uses polynomial 0xD5 (x^8+x^7+x^6+x^4+x^2+1), an initial value of 0x00, MSB-first shifting and no final inversion. It covers type, address, length and payload, and excludes both delimiters.
- R5: Each payload byte is the current `fifo_data`. `fifo_rd` is high for one cycle in each cycle where a payload byte is accepted. A frame pops exactly `msg_len` entries.
- R6: When the length is 0, the CRC byte directly follows the length byte and the FIFO is never read.
- R7: `busy` goes high in the cycle after `start` and falls in the cycle after the closing 0x15 is accepted. A `start` pulse while `busy` is high has no effect on the frame in progress, and no second frame follows it.
- R8: During the payload, `tx_valid` and `fifo_rd` are low while `fifo_empty` is high. The frame resumes when data arrives.
- R9: Type, address and length are captured in the `start` cycle. Later changes on `msg_type`, `msg_addr` and `msg_len` do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, taken when idle |
| msg_type | input | 8 | Message type code |
| msg_addr | input | 8 | Start address field |
| msg_len | input | 8 | Payload byte count |
| fifo_data | input | 8 | Head entry of the payload FIFO |
| fifo_empty | input | 1 | Payload FIFO holds no entry |
| fifo_rd | output | 1 | Pop the FIFO head |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| busy | output | 1 | Frame in progress |

## Verification
The bench drives the sink with three `tx_ready` patterns: always ready, every other cycle, and pseudo-random. An encoder that advanced on `tx_valid` alone would drop or repeat bytes, and a stall that disturbed `tx_byte` would be seen by the hold monitor. Frames of length 0, 1 and 255 catch an off-by-one in the payload counter, which shows up as one FIFO pop too many or too few and a shifted CRC. A request issued mid-frame and garbage placed on the request inputs after `start` would expose a design that restarts or re-samples its fields. An empty FIFO during the payload would expose a design that sends stale data or pops with nothing there.

// File: rtl/frm_enc_pkg.sv
// Shared constants and phase encoding for the frame encoder.
package frm_enc_pkg;
    localparam logic [7:0] FRM_OPEN_CODE  = 8'h00;
    localparam logic [7:0] FRM_CLOSE_CODE = 8'h15;
    localparam logic [7:0] FRM_CRC_POLY   = 8'hD5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_TYPE,
        PH_ADDR,
        PH_LEN,
        PH_DATA,
        PH_CRC,
        PH_CLOSE
    } frm_phase_t;
endpackage

// File: rtl/frm_crc_unit.sv
// Running CRC register, updated one byte per cycle.
// Assumes: clr and upd are never needed in the same cycle (clr wins).
// The polynomial is processed MSB first, with no reflection and no final xor.
module frm_crc_unit #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'hD5,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_q;
    logic [W-1:0] chain [0:W];

    assign chain[0] = crc_q;

    // One shift-and-reduce stage per input bit, MSB first.
    for (genvar gi = 0; gi < W; gi++) begin : g_stage
        logic fb;
        assign fb = chain[gi][W-1] ^ din[W-1-gi];
        assign chain[gi+1] = {chain[gi][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Register: clear on a new frame, fold in each accepted covered byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= INIT;
        else if (clr) crc_q <= INIT;
        else if (upd) crc_q <= chain[W];
    end

    assign crc = crc_q;

    a_r4_crc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(crc_q));
    a_r4_crc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == INIT));
endmodule

// File: rtl/frm_seq_ctrl.sv
// Frame sequencer: walks the fixed byte order, counts payload bytes,
// and generates the transmit handshake, FIFO pops and CRC controls.
// Assumes: the FIFO head stays put until popped, and the payload is
// preloaded (an empty FIFO only stalls the frame).
module frm_seq_ctrl
    import frm_enc_pkg::*;
#(
    parameter int W     = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     msg_type,
    input  logic [W-1:0]     msg_addr,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             fifo_empty,
    input  logic             tx_ready,
    output frm_phase_t       phase,
    output logic [W-1:0]     type_q,
    output logic [W-1:0]     addr_q,
    output logic [LEN_W-1:0] len_q,
    output logic             tx_valid,
    output logic             fifo_rd,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic             busy
);
    frm_phase_t       ph_q, ph_d;
    logic [LEN_W-1:0] cnt_q;
    logic             fire;
    logic             last_data;

    // Handshake: hold valid except while the payload source is empty.
    always_comb begin
        tx_valid = (ph_q != PH_IDLE) && !((ph_q == PH_DATA) && fifo_empty);
        fire     = tx_valid && tx_ready;
        fifo_rd  = fire && (ph_q == PH_DATA);
        crc_clr  = (ph_q == PH_IDLE) && start;
        crc_upd  = fire && ((ph_q == PH_TYPE) || (ph_q == PH_ADDR) ||
                            (ph_q == PH_LEN)  || (ph_q == PH_DATA));
        last_data = (cnt_q + LEN_W'(1)) == len_q;
    end

    // Next phase: advance only on an accepted byte.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (start) ph_d = PH_OPEN;
            PH_OPEN:  if (fire)  ph_d = PH_TYPE;
            PH_TYPE:  if (fire)  ph_d = PH_ADDR;
            PH_ADDR:  if (fire)  ph_d = PH_LEN;
            PH_LEN:   if (fire)  ph_d = (len_q == '0) ? PH_CRC : PH_DATA;
            PH_DATA:  if (fire && last_data) ph_d = PH_CRC;
            PH_CRC:   if (fire)  ph_d = PH_CLOSE;
            PH_CLOSE: if (fire)  ph_d = PH_IDLE;
            default:             ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Request capture, only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else if (ph_q == PH_IDLE && start) begin
            type_q <= msg_type;
            addr_q <= msg_addr;
            len_q  <= msg_len;
        end
    end

    // Payload counter: cleared on the length byte, stepped per payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (ph_q == PH_LEN)           cnt_q <= '0;
        else if (fire && ph_q == PH_DATA)  cnt_q <= cnt_q + LEN_W'(1);
    end

    assign phase = ph_q;
    assign busy  = (ph_q != PH_IDLE);

    a_r3_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && ph_q == $past(ph_q)));
    a_r5_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (tx_valid && tx_ready));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DATA) |-> (cnt_q < len_q));
    a_r6_zero_len_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LEN && fire && len_q == '0) |=> (ph_q == PH_CRC));
    a_r7_valid_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(type_q) && $stable(addr_q) && $stable(len_q)));
endmodule

// File: rtl/frm_byte_mux.sv
// Selects the byte offered to the transmitter for the current phase.
// Assumes: the payload byte comes straight from the FIFO head.
module frm_byte_mux
    import frm_enc_pkg::*;
#(
    parameter int           W          = 8,
    parameter int           LEN_W      = 8,
    parameter logic [W-1:0] OPEN_CODE  = FRM_OPEN_CODE,
    parameter logic [W-1:0] CLOSE_CODE = FRM_CLOSE_CODE
) (
    input  frm_phase_t       phase,
    input  logic [W-1:0]     type_q,
    input  logic [W-1:0]     addr_q,
    input  logic [LEN_W-1:0] len_q,
    input  logic [W-1:0]     fifo_data,
    input  logic [W-1:0]     crc,
    output logic [W-1:0]     byte_out
);
    // Phase to byte select.
    always_comb begin
        case (phase)
            PH_OPEN:  byte_out = OPEN_CODE;
            PH_TYPE:  byte_out = type_q;
            PH_ADDR:  byte_out = addr_q;
            PH_LEN:   byte_out = W'(len_q);
            PH_DATA:  byte_out = fifo_data;
            PH_CRC:   byte_out = crc;
            PH_CLOSE: byte_out = CLOSE_CODE;
            default:  byte_out = '0;
        endcase
    end
endmodule

// File: rtl/frm_encoder.sv
// Top of the framed reply encoder: sequencer, CRC register and byte select.
// Assumes: first-word-fall-through payload FIFO, loaded before start.
module frm_encoder
    import frm_enc_pkg::*;
#(
    parameter int           W     = 8,
    parameter int           LEN_W = 8,
    parameter logic [W-1:0] POLY  = FRM_CRC_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     msg_type,
    input  logic [W-1:0]     msg_addr,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [W-1:0]     fifo_data,
    input  logic             fifo_empty,
    output logic             fifo_rd,
    output logic [W-1:0]     tx_byte,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             busy
);
    frm_phase_t       phase;
    logic [W-1:0]     type_q, addr_q, crc;
    logic [LEN_W-1:0] len_q;
    logic             crc_clr, crc_upd;

    frm_seq_ctrl #(.W(W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .msg_type(msg_type), .msg_addr(msg_addr), .msg_len(msg_len),
        .fifo_empty(fifo_empty), .tx_ready(tx_ready),
        .phase(phase), .type_q(type_q), .addr_q(addr_q), .len_q(len_q),
        .tx_valid(tx_valid), .fifo_rd(fifo_rd),
        .crc_clr(crc_clr), .crc_upd(crc_upd), .busy(busy)
    );

    frm_crc_unit #(.W(W), .POLY(POLY), .INIT('0)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din(tx_byte), .crc(crc)
    );

    frm_byte_mux #(.W(W), .LEN_W(LEN_W)) u_mux (
        .phase(phase), .type_q(type_q), .addr_q(addr_q), .len_q(len_q),
        .fifo_data(fifo_data), .crc(crc), .byte_out(tx_byte)
    );

    a_r2_open_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_valid && tx_byte == FRM_OPEN_CODE));
    a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !fifo_rd) |=> (tx_valid && (phase == PH_DATA || $stable(tx_byte))));
    a_r8_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && fifo_empty) |-> (!tx_valid && !fifo_rd));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tx_valid));
endmodule

// File: tb/tb_frm_encoder.sv
module tb_frm_encoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       start = 0;
    logic [7:0] msg_type = 0, msg_addr = 0, msg_len = 0;
    logic [7:0] fifo_data;
    logic       fifo_empty;
    logic       fifo_rd;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       tx_ready = 0;
    logic       busy;

    int checks = 0, fails = 0, cyc = 0;

    // Payload FIFO model (first word fall through).
    logic [7:0] fmem [0:255];
    logic [7:0] wrp = 0, rdp = 0;
    int         pops = 0;
    assign fifo_data  = fmem[rdp];
    assign fifo_empty = (rdp == wrp);

    // Sink model.
    int         rdy_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    int         phase_t = 0;

    // Capture.
    logic [7:0] cap [0:299];
    int         ncap = 0;
    int         hold_viol = 0;
    logic       hold_pend = 0;
    logic [7:0] hold_byte = 0;

    frm_encoder dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .msg_type(msg_type), .msg_addr(msg_addr), .msg_len(msg_len),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fifo_rd) begin
            rdp  <= rdp + 8'd1;
            pops <= pops + 1;
        end
    end

    always @(posedge clk) begin
        #1;
        phase_t = phase_t + 1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = phase_t[0];
            default: tx_ready = lfsr[0] | lfsr[2];
        endcase
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !(tx_valid && tx_byte == hold_byte))
                hold_viol = hold_viol + 1;
            hold_pend = tx_valid && !tx_ready;
            hold_byte = tx_byte;
            if (tx_valid && tx_ready) begin
                if (ncap < 300) cap[ncap] = tx_byte;
                ncap = ncap + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[7] ^ d[b]) r = {r[6:0], 1'b0} ^ 8'hD5;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'((seed * 13 + i * 37) ^ (i >> 3));
    endfunction

    // Compare the captured frame with the expected one (R2, R4, R5).
    task automatic check_frame(input logic [7:0] ty, ad, ln, input int seed, input string tag);
        logic [7:0] exp_b [0:299];
        logic [7:0] c = 8'h00;
        int n = int'(ln) + 6;
        int bad = -1;
        exp_b[0] = 8'h00; exp_b[1] = ty; exp_b[2] = ad; exp_b[3] = ln;
        for (int i = 0; i < int'(ln); i++) exp_b[4+i] = pay(seed, i);
        for (int i = 1; i < 4 + int'(ln); i++) c = ref_crc(c, exp_b[i]);
        exp_b[4+int'(ln)] = c;
        exp_b[5+int'(ln)] = 8'h15;
        chk(ncap == n, "R2", {tag, " byte count"}, ncap, n);
        for (int i = 0; i < n && i < ncap; i++)
            if (i != 4 + int'(ln) && cap[i] !== exp_b[i] && bad < 0) bad = i;
        chk(bad < 0, "R2", {tag, " frame order/content"}, bad, -1);
        chk(ncap >= n && cap[4+int'(ln)] == c, "R4", {tag, " crc byte"},
            int'(cap[4+int'(ln)]), int'(c));
        chk(pops == int'(ln), "R5", {tag, " fifo pops"}, pops, int'(ln));
        chk(hold_viol == 0, "R3", {tag, " byte held under stall"}, hold_viol, 0);
    endtask

    task automatic run_frame(input logic [7:0] ty, ad, ln, input int seed,
                             input int mode, input string tag);
        int t = 0;
        rdy_mode = mode;
        @(negedge clk);
        for (int i = 0; i < int'(ln); i++) begin
            fmem[wrp] = pay(seed, i);
            wrp = wrp + 8'd1;
        end
        pops = 0; ncap = 0; hold_viol = 0;
        chk(busy == 1'b0, "R7", {tag, " idle before start"}, busy, 0);
        start = 1; msg_type = ty; msg_addr = ad; msg_len = ln;
        @(negedge clk);
        start = 0; msg_type = ~ty; msg_addr = ~ad; msg_len = ln + 8'd7;  // R9 garbage
        chk(busy && tx_valid && tx_byte == 8'h00, "R2", {tag, " open byte after start"},
            int'(tx_byte), 0);
        chk(busy == 1'b1, "R7", {tag, " busy after start"}, busy, 1);
        @(negedge clk); @(negedge clk);
        start = 1; msg_type = 8'hAA; msg_addr = 8'hBB; msg_len = 8'd5;  // R7 ignored
        @(negedge clk);
        start = 0;
        while (ncap < int'(ln) + 6 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && tx_valid == 1'b0, "R7", {tag, " idle after close, no second frame"},
            {busy, tx_valid}, 0);
        check_frame(ty, ad, ln, seed, tag);
        chk(fifo_empty == 1'b1, "R5", {tag, " fifo drained exactly"}, fifo_empty, 1);
    endtask

    // R8: payload stalls on an empty FIFO and resumes when filled.
    task automatic run_empty_stall();
        int t = 0;
        rdy_mode = 0;
        @(negedge clk);
        pops = 0; ncap = 0; hold_viol = 0;
        start = 1; msg_type = 8'h18; msg_addr = 8'h21; msg_len = 8'd3;
        @(negedge clk);
        start = 0;
        repeat (12) @(negedge clk);
        chk(ncap == 4, "R8", "header sent then stalled", ncap, 4);
        chk(tx_valid == 1'b0 && fifo_rd == 1'b0 && busy == 1'b1, "R8",
            "valid and pop low while empty", {tx_valid, fifo_rd, busy}, 1);
        for (int i = 0; i < 3; i++) begin
            fmem[wrp] = pay(9, i);
            wrp = wrp + 8'd1;
        end
        while (ncap < 9 && t < 1000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check_frame(8'h18, 8'h21, 8'd3, 9, "stall");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) fmem[i] = 8'h00;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !busy && !fifo_rd, "R1", "outputs in reset",
            {tx_valid, busy, fifo_rd}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_valid && !busy && !fifo_rd, "R1", "outputs after reset",
            {tx_valid, busy, fifo_rd}, 0);

        run_frame(8'h07, 8'h10, 8'd4,   1, 0, "reply4");
        run_frame(8'h18, 8'h3C, 8'd0,   2, 1, "R6_zero_len");
        run_frame(8'h07, 8'hF0, 8'd1,   3, 2, "len1");
        run_frame(8'h07, 8'h55, 8'd16,  4, 1, "alt16");
        run_frame(8'h18, 8'h00, 8'd255, 5, 2, "max255");
        run_empty_stall();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule